// File: doc/BRIEF.md
# Debug Halt Request Controller

This block decides when a processor core stops normal execution and enters its hardware debug mode. There are two ways to ask for entry. An external run/stop pin, active low and possibly asynchronous to the core clock, must be held until it is recognized. A single-cycle strobe from the test-access-port instruction decoder records a request until it is taken. In both cases entry happens only at an instruction-retirement boundary.

While the core is in a locked cycle, a special bus cycle, an interrupt-acknowledge cycle or the stop-clock state, the pin is not sampled. The pending state is frozen during that time, not cleared. At a boundary the debug request is arbitrated against a vector of other interrupt requests. Vector bit 0 outranks debug, and every other bit ranks below it. On entry the block first commands a pipeline flush and raises the debug-ready acknowledge. It waits for the pipeline to report the flush complete, and stays in debug until the core sends a resume strobe while the pin is released.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: The pin passes through two synchronizer flops and a pending latch. A boundary on any of the first four rising edges after the pin falls does not start entry. A boundary on the fifth edge does.
- R2: A pending request with no boundary never starts entry. `flush_cmd` and `dbg_rdy` stay low.
- R3: A boundary that recognizes the debug request makes both `flush_cmd` and `dbg_rdy` high from the next cycle.
- R4: `flush_cmd` stays high until `flush_done` is sampled high, and falls in the following cycle. `dbg_rdy` stays high.
- R5: A pin assertion that is released before any boundary arrives is dropped. A later boundary does not start entry.
- R6: While any of `locked_cyc`, `special_cyc`, `inta_cyc` or `stop_clk` is high, the pin is not sampled and the pending state is held. A request first made while blocked is taken only after blocking ends. A request pending before blocking survives a release of the pin during blocking.
- R7: A single-cycle `tap_dbg_enter` strobe, with the pin never asserted, leads to entry at a later boundary.
- R8: If `irq_pend[0]` is high at the boundary, `irq_grant` is 4'b0001 and debug entry waits. If only `irq_pend[1]` or higher bits are high, debug wins and `irq_grant` is zero.
- R9: With no debug request winning, a boundary grants the lowest set index of `irq_pend` as a one-hot `irq_grant`. There is no grant outside a boundary or during debug.
- R10: A resume strobe has no effect while the pin is still asserted. With the pin released, a resume strobe drops `dbg_rdy` in the next cycle, and the block then stays idle.
- R11: After reset, `flush_cmd`, `dbg_rdy` and `irq_grant` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_stop_n | input | 1 | External run/stop request, active low, may be asynchronous |
| tap_dbg_enter | input | 1 | Single-cycle debug-entry strobe from the test-port instruction decoder |
| retire_bnd | input | 1 | Instruction-retirement boundary this cycle |
| locked_cyc | input | 1 | Locked bus cycle in progress (blocks sampling) |
| special_cyc | input | 1 | Special bus cycle in progress (blocks sampling) |
| inta_cyc | input | 1 | Interrupt-acknowledge cycle in progress (blocks sampling) |
| stop_clk | input | 1 | Stop-clock state (blocks sampling) |
| irq_pend | input | NUM_IRQ | Other interrupt requests; bit 0 outranks debug, the rest rank below |
| flush_done | input | 1 | Pipeline reports the flush complete |
| resume | input | 1 | Core strobe requesting exit from debug |
| irq_grant | output | NUM_IRQ | One-hot grant to another interrupt at a boundary |
| flush_cmd | output | 1 | Pipeline-flush command, held until `flush_done` |
| dbg_rdy | output | 1 | Debug-ready acknowledge |

## Verification
The hardest situation to reach is a request that is pending when sampling becomes blocked, with the pin then released while it is still blocked. Only the frozen latch should carry that request to entry. The stimulus first lets the pin settle into the pending state, then raises `locked_cyc`, then raises the pin. It waits well past the synchronizer delay before presenting a boundary. A second ordering is also covered: the pin goes low while one of the four blocking sources is already high. That ordering is repeated for each source in turn, so that no source can be dropped from the block term without notice.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DBG   = 2'd3
  } dbg_state_e;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_req_latch.sv
module dbg_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_req_i,
  input  logic tap_req_i,
  input  logic blk_i,
  input  logic load_en_i,
  input  logic consume_i,
  output logic pend_o
);
  logic pin_pend_q, pin_pend_d;
  logic tap_pend_q, tap_pend_d;

  always_comb begin
    pin_pend_d = pin_pend_q;
    if (consume_i || !load_en_i) pin_pend_d = 1'b0;
    else if (!blk_i)             pin_pend_d = pin_req_i;

    tap_pend_d = tap_pend_q;
    if (consume_i)                   tap_pend_d = 1'b0;
    else if (tap_req_i && load_en_i) tap_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_pend_q <= 1'b0;
      tap_pend_q <= 1'b0;
    end else begin
      pin_pend_q <= pin_pend_d;
      tap_pend_q <= tap_pend_d;
    end
  end

  assign pend_o = pin_pend_q | tap_pend_q;

  // R6: sampling blocked freezes the pin latch
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_i && load_en_i && !consume_i) |=> $stable(pin_pend_q));
endmodule

// File: rtl/dbg_irq_arb.sv
module dbg_irq_arb #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bnd_i,
  input  logic               arb_en_i,
  input  logic               dbg_pend_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  output logic [NUM_IRQ-1:0] irq_grant_o,
  output logic               dbg_win_o
);
  logic active;
  logic found;

  assign active = bnd_i && arb_en_i;

  always_comb begin
    irq_grant_o = '0;
    dbg_win_o   = 1'b0;
    found       = 1'b0;
    if (active) begin
      if (irq_pend_i[0]) begin
        irq_grant_o[0] = 1'b1;
        found = 1'b1;
      end else if (dbg_pend_i) begin
        dbg_win_o = 1'b1;
        found = 1'b1;
      end
      for (int i = 1; i < NUM_IRQ; i++) begin
        if (!found && irq_pend_i[i]) begin
          irq_grant_o[i] = 1'b1;
          found = 1'b1;
        end
      end
    end
  end

  // R9: at most one grant, none outside an arbitration point
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_grant_o, dbg_win_o}));
  a_r9_no_bnd: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_i |-> (irq_grant_o == '0));
  // R8: top source outranks debug
  a_r8_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (active && irq_pend_i[0]) |-> (irq_grant_o[0] && !dbg_win_o));
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_halt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic bnd_i,
  input  logic dbg_win_i,
  input  logic pin_req_i,
  input  logic flush_done_i,
  input  logic resume_i,
  output logic load_en_o,
  output logic arb_en_o,
  output logic dbg_pend_o,
  output logic consume_o,
  output logic flush_cmd_o,
  output logic dbg_rdy_o
);
  dbg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (pend_i) state_d = ST_PEND;
      ST_PEND: begin
        if (dbg_win_i)    state_d = ST_FLUSH;
        else if (!pend_i) state_d = ST_IDLE;
      end
      ST_FLUSH: if (flush_done_i) state_d = ST_DBG;
      ST_DBG:   if (resume_i && !pin_req_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load_en_o   = (state_q == ST_IDLE) || (state_q == ST_PEND);
  assign arb_en_o    = load_en_o;
  assign dbg_pend_o  = (state_q == ST_PEND);
  assign consume_o   = dbg_win_i;
  assign flush_cmd_o = (state_q == ST_FLUSH);
  assign dbg_rdy_o   = (state_q == ST_FLUSH) || (state_q == ST_DBG);

  // R2: no entry without a boundary
  a_r2_bnd_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND && !bnd_i) |=> !flush_cmd_o);
  // R3: recognition yields flush and acknowledge next cycle
  a_r3_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND && dbg_win_i) |=> (flush_cmd_o && dbg_rdy_o));
  // R4: flush held until done
  a_r4_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_cmd_o && !flush_done_i) |=> flush_cmd_o);
  // R10: exit needs resume with pin released
  a_r10_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DBG && resume_i && !pin_req_i) |=> !dbg_rdy_o);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DBG && pin_req_i) |=> dbg_rdy_o);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl #(
  parameter int NUM_IRQ   = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_stop_n,
  input  logic               tap_dbg_enter,
  input  logic               retire_bnd,
  input  logic               locked_cyc,
  input  logic               special_cyc,
  input  logic               inta_cyc,
  input  logic               stop_clk,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic               flush_done,
  input  logic               resume,
  output logic [NUM_IRQ-1:0] irq_grant,
  output logic               flush_cmd,
  output logic               dbg_rdy
);
  logic rst_ns;
  logic pin_sync_n;
  logic pin_req;
  logic blocked;
  logic pend, load_en, arb_en, dbg_pend, consume, dbg_win;

  dbg_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_ns)
  );

  dbg_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_ns), .d_i(run_stop_n), .q_o(pin_sync_n)
  );

  assign pin_req = !pin_sync_n;
  assign blocked = locked_cyc | special_cyc | inta_cyc | stop_clk;

  dbg_req_latch u_latch (
    .clk(clk), .rst_n(rst_ns), .pin_req_i(pin_req), .tap_req_i(tap_dbg_enter),
    .blk_i(blocked), .load_en_i(load_en), .consume_i(consume), .pend_o(pend)
  );

  dbg_irq_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .clk(clk), .rst_n(rst_ns), .bnd_i(retire_bnd), .arb_en_i(arb_en),
    .dbg_pend_i(dbg_pend), .irq_pend_i(irq_pend), .irq_grant_o(irq_grant),
    .dbg_win_o(dbg_win)
  );

  dbg_entry_fsm u_fsm (
    .clk(clk), .rst_n(rst_ns), .pend_i(pend), .bnd_i(retire_bnd),
    .dbg_win_i(dbg_win), .pin_req_i(pin_req), .flush_done_i(flush_done),
    .resume_i(resume), .load_en_o(load_en), .arb_en_o(arb_en),
    .dbg_pend_o(dbg_pend), .consume_o(consume), .flush_cmd_o(flush_cmd),
    .dbg_rdy_o(dbg_rdy)
  );

  // R11: quiet outputs while internal reset is held
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_ns |-> (!flush_cmd && !dbg_rdy && irq_grant == '0));
endmodule

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic run_stop_n, tap_dbg_enter, retire_bnd;
  logic locked_cyc, special_cyc, inta_cyc, stop_clk;
  logic [3:0] irq_pend, irq_grant;
  logic flush_done, resume, flush_cmd, dbg_rdy;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_halt_ctrl u_dbg_halt_ctrl (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bnd_pulse();
    retire_bnd = 1'b1;
    step(1);
    retire_bnd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run_stop_n = 1'b1; tap_dbg_enter = 1'b0; retire_bnd = 1'b0;
    locked_cyc = 0; special_cyc = 0; inta_cyc = 0; stop_clk = 0;
    irq_pend = '0; flush_done = 0; resume = 0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 flush", flush_cmd, 0);
    chk("R11 rdy", dbg_rdy, 0);
    chk("R11 grant", irq_grant, 0);
  endtask

  task automatic t_sync_delay();
    do_reset();
    run_stop_n = 1'b0;
    retire_bnd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1);
      chk("R1 early edge", flush_cmd, 0);
    end
    retire_bnd = 1'b0;
    bnd_pulse();
    chk("R1 fifth edge flush", flush_cmd, 1);
  endtask

  task automatic t_no_bnd_and_entry();
    do_reset();
    run_stop_n = 1'b0;
    step(20);
    chk("R2 flush", flush_cmd, 0);
    chk("R2 rdy", dbg_rdy, 0);
    bnd_pulse();
    chk("R3 flush", flush_cmd, 1);
    chk("R3 rdy", dbg_rdy, 1);
    step(3);
    chk("R4 flush held", flush_cmd, 1);
    flush_done = 1'b1;
    step(1);
    flush_done = 1'b0;
    chk("R4 flush drop", flush_cmd, 0);
    chk("R4 rdy kept", dbg_rdy, 1);
    resume = 1'b1;
    step(1);
    resume = 1'b0;
    chk("R10 resume while held", dbg_rdy, 1);
    run_stop_n = 1'b1;
    step(4);
    resume = 1'b1;
    step(1);
    resume = 1'b0;
    chk("R10 exit", dbg_rdy, 0);
    step(5);
    bnd_pulse();
    chk("R10 stays idle", dbg_rdy, 0);
  endtask

  task automatic t_short_pulse();
    do_reset();
    run_stop_n = 1'b0;
    step(6);
    run_stop_n = 1'b1;
    step(6);
    bnd_pulse();
    chk("R5 dropped pulse", flush_cmd, 0);
    chk("R5 rdy", dbg_rdy, 0);
  endtask

  task automatic t_blocking();
    for (int s = 0; s < 4; s++) begin
      do_reset();
      locked_cyc = (s == 0); special_cyc = (s == 1);
      inta_cyc = (s == 2); stop_clk = (s == 3);
      run_stop_n = 1'b0;
      step(8);
      bnd_pulse();
      chk($sformatf("R6 blocked src%0d", s), flush_cmd, 0);
      locked_cyc = 0; special_cyc = 0; inta_cyc = 0; stop_clk = 0;
      step(3);
      bnd_pulse();
      chk($sformatf("R6 after unblock src%0d", s), flush_cmd, 1);
    end
    do_reset();
    run_stop_n = 1'b0;
    step(6);
    locked_cyc = 1'b1;
    run_stop_n = 1'b1;
    step(6);
    bnd_pulse();
    chk("R6 frozen pending", flush_cmd, 1);
  endtask

  task automatic t_tap();
    do_reset();
    tap_dbg_enter = 1'b1;
    step(1);
    tap_dbg_enter = 1'b0;
    step(5);
    chk("R7 no boundary yet", flush_cmd, 0);
    bnd_pulse();
    chk("R7 tap entry", flush_cmd, 1);
    chk("R7 rdy", dbg_rdy, 1);
  endtask

  task automatic t_priority();
    do_reset();
    run_stop_n = 1'b0;
    step(6);
    irq_pend = 4'b0001;
    retire_bnd = 1'b1;
    #1 chk("R8 top grant", irq_grant, 4'b0001);
    step(1);
    retire_bnd = 1'b0;
    chk("R8 debug waits", flush_cmd, 0);
    irq_pend = 4'b0100;
    retire_bnd = 1'b1;
    #1 chk("R8 debug beats low", irq_grant, 0);
    step(1);
    retire_bnd = 1'b0;
    chk("R8 debug entry", flush_cmd, 1);
    retire_bnd = 1'b1;
    #1 chk("R9 no grant in debug", irq_grant, 0);
    retire_bnd = 1'b0;
  endtask

  task automatic t_irq_only();
    do_reset();
    irq_pend = 4'b0110;
    #1 chk("R9 no boundary", irq_grant, 0);
    retire_bnd = 1'b1;
    #1 chk("R9 lowest index", irq_grant, 4'b0010);
    irq_pend = 4'b1000;
    #1 chk("R9 single high", irq_grant, 4'b1000);
    irq_pend = 4'b1011;
    #1 chk("R9 top among many", irq_grant, 4'b0001);
    retire_bnd = 1'b0;
    irq_pend = '0;
  endtask

  initial begin
    t_reset();
    t_sync_delay();
    t_no_bnd_and_entry();
    t_short_pulse();
    t_blocking();
    t_tap();
    t_priority();
    t_irq_only();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule